// File: doc/BRIEF.md
# Prescaled Up/Down Timer Counter Channel

This block is a single timer channel built around a 16-bit counter. The counter steps on a tick taken either straight from the input clock or from a power-of-two divider. It counts up or down and wraps either across its full 16-bit range or across a programmable interval. Three compare values each watch the count. Wraps and compare hits latch into a 6-bit sticky status word. Software-facing logic sits outside the block. It supplies the clock-control and interval levels, the three compare values, a counter-control write strobe with data, and a strobe that clears the status word.

The counter-control word is held inside the block. Its reset field is an action and not a setting: writing it zeroes the count and restarts the divider, and it is never stored. A single `irq_pending` output shows whether any status bit is set.

Top module: `ptc_channel`

## Requirements
- R1: After reset the count is 0, the status word is 0, `irq_pending` is 0 and `ctrl_rd` reads 0x21, so the counter is held.
- R2: With `clk_ctrl[0]`=0 the count steps on every clock. With `clk_ctrl[0]`=1 it steps once every 2^(N+1) clocks, where N=`clk_ctrl[4:1]`. The divider restarts from zero while the counter is disabled or being reset, so the first step after enabling comes one full period later.
- R3: The counter-control fields are: bit 0 stops counting, bit 1 selects interval wrap, bit 2 selects counting down, bit 3 enables compares, bit 4 zeroes the count, and bit 5 is stored. Bit 4 always reads back as 0. The count holds while bit 0 is set.
- R4: Counting up, the count goes 0..limit and then wraps to 0. The limit is `interval` in interval mode and 0xFFFF otherwise, so the period is limit+1.
- R5: Counting down, a step from 0 reloads the count to the limit.
- R6: A wrap in either direction sets status bit 0 in interval mode and status bit 4 otherwise.
- R7: Compare k (k=1..3, on `match_a`/`match_b`/`match_c`) sets status bit k when the count takes that value. This happens only while the compare enable is 1, and never when the compare value exceeds the limit.
- R8: Status bits stay set until `status_clr`. A bit being set in the same cycle as a clear stays set. Status bit 5 stays 0.
- R9: `irq_pending` is 1 exactly when some status bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ctrl | input | 5 | Bit 0 divider enable, bits 4:1 divider exponent N |
| ctrl_wr | input | 1 | Counter-control write strobe |
| ctrl_wdata | input | 6 | Counter-control write data |
| ctrl_rd | output | 6 | Stored counter-control word |
| interval | input | 16 | Interval-mode limit |
| match_a | input | 16 | Compare value 1 |
| match_b | input | 16 | Compare value 2 |
| match_c | input | 16 | Compare value 3 |
| status_clr | input | 1 | Clears the status word |
| count | output | 16 | Current count |
| irq_status | output | 6 | Sticky status word |
| irq_pending | output | 1 | Any status bit set |

## Verification
A divider that restarts at the wrong moment makes the first step after an enable arrive early or late, and this shows at `count` within one prescale period. A wrong wrap limit or reload value gives an out-of-sequence count on the very next tick after the limit. A wrong wrap or compare decode sets the wrong bit of `irq_status` on that same edge, and the bit then stays visible until a clear.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    localparam int CNT_W   = 16;
    localparam int CTRL_W  = 6;
    localparam int STAT_W  = 6;
    localparam int NMATCH  = 3;
    localparam int SEL_W   = 4;

    // counter-control bit positions
    localparam int CB_STOP  = 0;
    localparam int CB_INTVL = 1;
    localparam int CB_DOWN  = 2;
    localparam int CB_MEN   = 3;
    localparam int CB_ZERO  = 4;

    // status bit positions
    localparam int SB_INTVL = 0;
    localparam int SB_MATCH = 1;
    localparam int SB_OVF   = 4;
    localparam int SB_EVT   = 5;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 6'h21;
endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
    parameter int DIV_W = 16,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             div_en,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [DIV_W:0] period_m1;
    logic [SEL_W:0] shamt;

    always_comb begin
        shamt     = {1'b0, div_sel} + {{SEL_W{1'b0}}, 1'b1};
        period_m1 = ({{DIV_W{1'b0}}, 1'b1} << shamt) - {{DIV_W{1'b0}}, 1'b1};
        st_d      = st_q;
        tick      = 1'b0;
        if (!run) begin
            st_d.div = '0;
        end else if (!div_en) begin
            tick     = 1'b1;
            st_d.div = '0;
        end else if ({1'b0, st_q.div} == period_m1) begin
            tick     = 1'b1;
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + {{(DIV_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.div == '0);  // R2
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter #(
    parameter int CNT_W  = 16,
    parameter int NMATCH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic                         zero,
    input  logic                         intvl_mode,
    input  logic                         down,
    input  logic                         match_en,
    input  logic [CNT_W-1:0]             interval,
    input  logic [NMATCH-1:0][CNT_W-1:0] match_val,
    output logic [CNT_W-1:0]             count,
    output logic                         wrap,
    output logic [NMATCH-1:0]            match_hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             step;

    always_comb begin
        limit = intvl_mode ? interval : {CNT_W{1'b1}};
        step  = tick && !zero;
        st_d  = st_q;
        wrap  = 1'b0;
        if (zero) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (down) begin
                if (st_q.cnt == '0) begin
                    st_d.cnt = limit;
                    wrap     = 1'b1;
                end else if (st_q.cnt > limit) begin
                    st_d.cnt = limit;
                end else begin
                    st_d.cnt = st_q.cnt - {{(CNT_W-1){1'b0}}, 1'b1};
                end
            end else begin
                if (st_q.cnt >= limit) begin
                    st_d.cnt = '0;
                    wrap     = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
                end
            end
        end
    end

    for (genvar i = 0; i < NMATCH; i++) begin : g_cmp
        assign match_hit[i] = step && match_en && (match_val[i] <= limit)
                              && (st_d.cnt == match_val[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    AST_INTVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !zero && intvl_mode) |=> count <= $past(interval));  // R4
    AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !zero && down && count == '0) |=> count == $past(limit));  // R5
endmodule

// File: rtl/ptc_status.sv
module ptc_status #(
    parameter int STAT_W = 6,
    parameter int NMATCH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic              intvl_mode,
    input  logic [NMATCH-1:0] match_hit,
    input  logic              clr,
    output logic [STAT_W-1:0] status
);
    import ptc_pkg::*;

    typedef struct packed {
        logic [STAT_W-1:0] bits;
    } st_state_t;

    st_state_t st_d, st_q;
    logic [STAT_W-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        set_vec[SB_INTVL] = wrap && intvl_mode;
        set_vec[SB_OVF]   = wrap && !intvl_mode;
        set_vec[SB_MATCH +: NMATCH] = match_hit;
        st_d.bits = (clr ? '0 : st_q.bits) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.bits;

    AST_EVENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        status[SB_EVT] == 1'b0);  // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(status) & ~status) == '0));  // R8
endmodule

// File: rtl/ptc_channel.sv
module ptc_channel
    import ptc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W:0]    clk_ctrl,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rd,
    input  logic [W-1:0]      interval,
    input  logic [W-1:0]      match_a,
    input  logic [W-1:0]      match_b,
    input  logic [W-1:0]      match_c,
    input  logic              status_clr,
    output logic [W-1:0]      count,
    output logic [STAT_W-1:0] irq_status,
    output logic              irq_pending
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } top_state_t;

    top_state_t st_d, st_q;
    logic zero_req, run, tick, wrap;
    logic [NMATCH-1:0]        hits;
    logic [NMATCH-1:0][W-1:0] mvals;

    always_comb begin
        zero_req = ctrl_wr && ctrl_wdata[CB_ZERO];
        run      = !st_q.ctrl[CB_STOP] && !zero_req;
        st_d     = st_q;
        if (ctrl_wr) begin
            st_d.ctrl = ctrl_wdata;
            st_d.ctrl[CB_ZERO] = 1'b0;
        end
        mvals = {match_c, match_b, match_a};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ctrl <= CTRL_RESET;
        else        st_q <= st_d;
    end

    ptc_prescaler #(.DIV_W(W), .SEL_W(SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run),
        .div_en(clk_ctrl[0]), .div_sel(clk_ctrl[SEL_W:1]), .tick(tick)
    );

    ptc_counter #(.CNT_W(W), .NMATCH(NMATCH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .zero(zero_req),
        .intvl_mode(st_q.ctrl[CB_INTVL]), .down(st_q.ctrl[CB_DOWN]),
        .match_en(st_q.ctrl[CB_MEN]), .interval(interval), .match_val(mvals),
        .count(count), .wrap(wrap), .match_hit(hits)
    );

    ptc_status #(.STAT_W(STAT_W), .NMATCH(NMATCH)) u_stat (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .intvl_mode(st_q.ctrl[CB_INTVL]),
        .match_hit(hits), .clr(status_clr), .status(irq_status)
    );

    assign ctrl_rd     = st_q.ctrl;
    assign irq_pending = |irq_status;

    AST_ZERO_NOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[CB_ZERO] == 1'b0);  // R3
    AST_HELD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[CB_STOP] && !ctrl_wr) |=> count == $past(count));  // R3
endmodule

// File: tb/ptc_channel_bench.sv
module ptc_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  clk_ctrl = '0;
    logic        ctrl_wr = 1'b0;
    logic [5:0]  ctrl_wdata = '0;
    logic [5:0]  ctrl_rd;
    logic [15:0] interval = '0;
    logic [15:0] match_a = '0, match_b = '0, match_c = '0;
    logic        status_clr = 1'b0;
    logic [15:0] count;
    logic [5:0]  irq_status;
    logic        irq_pending;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ptc_channel u_ptc_channel (
        .clk(clk), .rst_n(rst_n), .clk_ctrl(clk_ctrl), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(ctrl_wdata), .ctrl_rd(ctrl_rd), .interval(interval),
        .match_a(match_a), .match_b(match_b), .match_c(match_c),
        .status_clr(status_clr), .count(count), .irq_status(irq_status),
        .irq_pending(irq_pending)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [5:0] v, logic clr);
        ctrl_wr = 1'b1; ctrl_wdata = v; status_clr = clr;
        step(1);
        ctrl_wr = 1'b0; status_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 status", irq_status, 0);
        chk("R1 ctrl", ctrl_rd, 'h21);
        chk("R9 pending", irq_pending, 0);
        step(20);
        chk("R1 held", count, 0);

        // R3 zero bit not stored, bit5 kept, stop keeps count
        wr(6'h3F, 1'b0);
        chk("R3 readback", ctrl_rd, 'h2F);
        step(5);
        chk("R3 stopped", count, 0);

        // R4/R6 full range up, overflow bit
        wr(6'h10, 1'b1);
        step(65535);
        chk("R4 top", count, 'hFFFF);
        chk("R6 no wrap yet", irq_status, 0);
        step(1);
        chk("R4 wrap", count, 0);
        chk("R6 overflow bit", irq_status, 'h10);
        chk("R9 pending", irq_pending, 1);

        // R5/R6 down in full range
        wr(6'h14, 1'b1);
        step(1);
        chk("R5 reload full", count, 'hFFFF);
        chk("R6 down overflow", irq_status, 'h10);

        // R4/R6 interval mode sweep, up and down
        foreach (interval_list[j]) begin
            interval = interval_list[j];
            wr(6'h12, 1'b1);
            for (int k = 1; k <= 2 * (interval_list[j] + 1) + 1; k++) begin
                step(1);
                chk("R4 interval up", count, k % (interval_list[j] + 1));
                chk("R6 interval bit up", irq_status, (k >= interval_list[j] + 1) ? 1 : 0);
            end
            wr(6'h16, 1'b1);
            for (int k = 1; k <= 2 * (interval_list[j] + 1) + 1; k++) begin
                step(1);
                chk("R5 interval down", count,
                    (interval_list[j] + 1 - k % (interval_list[j] + 1)) % (interval_list[j] + 1));
                chk("R6 interval bit down", irq_status, 1);
            end
        end

        // R2 prescaler periods
        for (int n = 0; n < 4; n++) begin
            int p;
            p = 1 << (n + 1);
            clk_ctrl = {n[3:0], 1'b1};
            wr(6'h10, 1'b1);
            for (int c = 1; c <= 3 * p; c++) begin
                step(1);
                chk("R2 divided rate", count, c / p);
            end
        end
        // R2 divider restart on disable
        clk_ctrl = {4'd2, 1'b1};
        wr(6'h10, 1'b1);
        step(9);
        chk("R2 before stop", count, 1);
        wr(6'h01, 1'b0);
        step(3);
        wr(6'h00, 1'b0);
        step(7);
        chk("R2 restart early", count, 1);
        step(1);
        chk("R2 restart full period", count, 2);
        clk_ctrl = '0;

        // R7 compares
        interval = 16'd9; match_a = 16'd3; match_b = 16'd7; match_c = 16'd12;
        wr(6'h1A, 1'b1);
        for (int k = 1; k <= 9; k++) begin
            step(1);
            chk("R7 compare bits", irq_status, ((k >= 3) ? 2 : 0) | ((k >= 7) ? 4 : 0));
        end
        step(11);
        chk("R7 over-limit compare silent", irq_status & 8, 0);
        wr(6'h12, 1'b1);
        step(20);
        chk("R7 compares disabled", irq_status, 1);

        // R8 sticky and set-over-clear
        interval = 16'd0;
        wr(6'h12, 1'b1);
        step(1);
        chk("R8 set", irq_status, 1);
        status_clr = 1'b1;
        step(1);
        status_clr = 1'b0;
        chk("R8 set wins", irq_status, 1);
        wr(6'h01, 1'b0);
        step(10);
        chk("R8 sticky", irq_status, 1);
        status_clr = 1'b1;
        step(1);
        status_clr = 1'b0;
        chk("R8 cleared", irq_status, 0);
        chk("R9 pending low", irq_pending, 0);
        step(5);
        chk("R8 stays clear", irq_status, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    int interval_list[5] = '{0, 1, 2, 5, 7};
endmodule